// File: doc/BRIEF.md
# Segmented Comparand Register with Partition Rotation

This block holds the 128-bit search key that a content-addressable array compares against every stored entry. Software-side logic loads and reads the key one 32-bit segment at a time, picking the segment with a 2-bit select. A per-bit write mask can protect any bits of the chosen segment from being overwritten. The full 128-bit value is always driven to the compare array.

A 3-bit partition code divides each word into a CAM field and a RAM field on 32-bit boundaries. The key can be rotated one bit left or right. The rotation wraps at the edges of the CAM field, not at the edges of the word. Bits in the RAM field do not move. This lets a search pattern be walked across the CAM part of the entry while the associated-data part of the key stays as it is.

Top module: `segcmp_reg`

## Requirements
- R1: After reset, `cmp_value` and `rd_data` are all zero and the partition is all-CAM (bits 127..0).
- R2: With `wr_en` high, segment `seg_sel` (bits 32*s+31..32*s) takes `wr_data` at the next edge, and the other three segments keep their value.
- R3: A `wr_mask` bit of 1 keeps the old value of that bit during a write. A mask bit of 0 lets the bit take the new data.
- R4: With `rd_en` high, `rd_data` shows segment `seg_sel` of the value held before that edge, one cycle after the strobe. Without `rd_en`, `rd_data` holds its value.
- R5: The partition code, loaded through `part_wr`, sets the CAM field as follows: 000 and 100 give bits 127..0; 001 gives 127..32; 010 gives 127..64; 011 gives 127..96; 101 gives 95..0; 110 gives 63..0; 111 gives 31..0.
- R6: `shr` alone moves every CAM bit one place toward bit 0. The bit at the lowest CAM position wraps to the highest CAM position.
- R7: `shl` alone moves every CAM bit one place toward the MSB. The bit at the highest CAM position wraps to the lowest CAM position.
- R8: Bits outside the CAM field do not change during a shift.
- R9: A write in the same cycle as a shift wins, and no shift takes place. `shl` and `shr` together cause no shift. With no write and no single shift command, `cmp_value` holds.
- R10: A shift in the same cycle as `part_wr` uses the partition that was in effect before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_sel | input | 2 | Segment select for writes and reads |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Segment write data |
| wr_mask | input | 128 | Per-bit write protect, 1 keeps the old bit |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered segment read data |
| shl | input | 1 | Rotate CAM field left by one |
| shr | input | 1 | Rotate CAM field right by one |
| part_wr | input | 1 | Load partition code |
| part_code | input | 3 | Partition code |
| cmp_value | output | 128 | Full register value to the compare array |

## Verification
The whole register is visible on `cmp_value` every cycle. A wrong bit after a write, a shift or a partition change therefore shows at the ports one edge after the operation that caused it. A wrong partition decode shows up as a misplaced wrap bit, or as a RAM bit that moves, on the first shift after the code is loaded. For this reason random shifts are mixed with partition loads under every code. The read path is checked one cycle after each strobe against the value held before the edge, which catches a read that returns stale data or data already updated by the same edge.

// File: rtl/segcmp_reg.sv
module segcmp_reg #(
  parameter int SEG_W = 32,
  localparam int NSEG = 4,
  localparam int W = SEG_W * NSEG,
  localparam int IW = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       seg_sel,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [W-1:0]     wr_mask,
  input  logic             rd_en,
  output logic [SEG_W-1:0] rd_data,
  input  logic             shl,
  input  logic             shr,
  input  logic             part_wr,
  input  logic [2:0]       part_code,
  output logic [W-1:0]     cmp_value
);

  logic [W-1:0] q, seg_field, cam_field, rot, wr_sel;
  logic [2:0]   part_q;
  logic [IW-1:0] lo, hi;
  logic          do_shift;

  always_comb begin
    unique case (part_q)
      3'b001:  begin lo = IW'(SEG_W);     hi = IW'(W-1); end
      3'b010:  begin lo = IW'(2*SEG_W);   hi = IW'(W-1); end
      3'b011:  begin lo = IW'(3*SEG_W);   hi = IW'(W-1); end
      3'b101:  begin lo = '0;             hi = IW'(3*SEG_W-1); end
      3'b110:  begin lo = '0;             hi = IW'(2*SEG_W-1); end
      3'b111:  begin lo = '0;             hi = IW'(SEG_W-1); end
      default: begin lo = '0;             hi = IW'(W-1); end
    endcase
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      cam_field[i] = (IW'(i) >= lo) && (IW'(i) <= hi);
      rot[i] = q[i];
      if (cam_field[i]) begin
        if (shr) rot[i] = (IW'(i) == hi) ? q[lo] : q[(i+1) % W];
        else     rot[i] = (IW'(i) == lo) ? q[hi] : q[(i+W-1) % W];
      end
    end
  end

  assign seg_field = {{(W-SEG_W){1'b0}}, {SEG_W{1'b1}}} << (seg_sel * SEG_W);
  assign wr_sel    = seg_field & ~wr_mask;
  assign do_shift  = (shl ^ shr) & ~wr_en;
  assign cmp_value = q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      part_q  <= 3'b000;
      rd_data <= '0;
    end else begin
      if (wr_en)         q <= (q & ~wr_sel) | ({NSEG{wr_data}} & wr_sel);
      else if (do_shift) q <= rot;
      if (part_wr)       part_q <= part_code;
      if (rd_en)         rd_data <= q[seg_sel*SEG_W +: SEG_W];
    end
  end

  AST_WR_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cmp_value ^ $past(cmp_value)) & ~$past(wr_sel)) == '0); // R3
  AST_RAM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (shl || shr)) |=> ((cmp_value ^ $past(cmp_value)) & ~$past(cam_field)) == '0); // R8
  AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (shl ^ shr)) |=> $countones(cmp_value) == $countones($past(cmp_value))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(shl ^ shr)) |=> $stable(cmp_value)); // R9
  AST_READ_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data == $past(cmp_value[seg_sel*SEG_W +: SEG_W])); // R4
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R4

endmodule

// File: tb/segcmp_reg_test.sv
module segcmp_reg_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] seg_sel = 0;
  logic wr_en = 0, rd_en = 0, shl = 0, shr = 0, part_wr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [127:0] wr_mask = 0, cmp_value;
  logic [2:0] part_code = 0;
  int tests = 0, fails = 0;
  logic [127:0] exp_v;
  logic [31:0] exp_rd;
  logic [2:0] exp_part;
  string tag;

  always #2.5 clk = ~clk;

  segcmp_reg uut (.clk, .rst_n, .seg_sel, .wr_en, .wr_data, .wr_mask, .rd_en,
                  .rd_data, .shl, .shr, .part_wr, .part_code, .cmp_value);

  function automatic int lo_of(logic [2:0] c);
    case (c) 3'b001: return 32; 3'b010: return 64; 3'b011: return 96; default: return 0; endcase
  endfunction
  function automatic int hi_of(logic [2:0] c);
    case (c) 3'b101: return 95; 3'b110: return 63; 3'b111: return 31; default: return 127; endcase
  endfunction
  function automatic logic [127:0] rot_r(logic [127:0] v, logic [2:0] c);
    logic [127:0] t = v;
    for (int i = lo_of(c); i < hi_of(c); i++) t[i] = v[i+1];
    t[hi_of(c)] = v[lo_of(c)];
    return t;
  endfunction
  function automatic logic [127:0] rot_l(logic [127:0] v, logic [2:0] c);
    logic [127:0] t = v;
    for (int i = lo_of(c) + 1; i <= hi_of(c); i++) t[i] = v[i-1];
    t[lo_of(c)] = v[hi_of(c)];
    return t;
  endfunction

  task automatic check(string t);
    tests++;
    if (cmp_value !== exp_v) begin
      fails++;
      $display("FAIL %s cmp_value=%h expected=%h", t, cmp_value, exp_v);
    end
    tests++;
    if (rd_data !== exp_rd) begin
      fails++;
      $display("FAIL R4 rd_data=%h expected=%h (after %s)", rd_data, exp_rd, t);
    end
  endtask

  task automatic step(logic w, logic [1:0] s, logic [31:0] d, logic [127:0] m,
                      logic r, logic l, logic rr, logic pw, logic [2:0] pc);
    logic [127:0] f;
    wr_en = w; seg_sel = s; wr_data = d; wr_mask = m; rd_en = r;
    shl = l; shr = rr; part_wr = pw; part_code = pc;
    if (r) exp_rd = exp_v[s*32 +: 32];
    if (w) begin
      f = (128'hFFFF_FFFF << (s*32)) & ~m;
      exp_v = (exp_v & ~f) | ({4{d}} & f);
      tag = (l || rr) ? "R9" : ((m != 0) ? "R3" : "R2");
    end else if (rr && !l) begin
      exp_v = rot_r(exp_v, exp_part);
      tag = pw ? "R10" : (exp_part[1:0] != 0 ? "R5/R8" : "R6");
    end else if (l && !rr) begin
      exp_v = rot_l(exp_v, exp_part);
      tag = pw ? "R10" : (exp_part[1:0] != 0 ? "R5/R8" : "R7");
    end else tag = "R9";
    if (pw) exp_part = pc;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_v = '0; exp_rd = '0; exp_part = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);                    // R1: rotate of zero stays zero
    step(1, 1, 32'h0000_0001, 0, 0, 0, 0, 1, 3'b001);   // R2 write bit 32, load code 001
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);                    // R5: bit 32 wraps to bit 127
    tests++;
    if (cmp_value[127] !== 1'b1) begin
      fails++;
      $display("FAIL R5 bit127=%b expected=1", cmp_value[127]);
    end
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);                    // R7: bit 127 wraps to bit 32
    step(0, 1, 0, 0, 1, 0, 0, 0, 0);                    // R4 read segment 1
    tests++;
    if (rd_data !== 32'h0000_0001) begin
      fails++;
      $display("FAIL R4 rd_data=%h expected=00000001", rd_data);
    end
    step(1, 3, 32'hFFFF_FFFF, {32'hF0F0_F0F0, 96'h0}, 0, 1, 1, 0, 0); // R3 + R9
    step(0, 0, 0, 0, 0, 1, 1, 0, 0);                    // R9 both shifts, no change
    for (int n = 0; n < 4000; n++) begin
      logic [127:0] m;
      m = ($urandom_range(0, 2) == 0) ? {$urandom, $urandom, $urandom, $urandom} : '0;
      step($urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)), $urandom, m,
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 9) == 0, 3'($urandom_range(0, 7)));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule